// File: doc/BRIEF.md
# Ping-Pong Receive Channel Buffer Bank

This block sits between a TDM demultiplexer and a processor on the receive path. The demultiplexer delivers single bytes, each tagged with a channel number. The block packs them into 32-bit words and holds them in five double-buffered channels: four packet channels and one voice channel. Each channel has two halves. The hardware fills one half while software drains the other. When a half is complete it is handed to software as a whole, and the fill side moves on to the other half.

Software polls the per-half ready flags and reads a finished half word by word. Reading the last word of a half returns the half to the hardware. If the hardware needs a half that software still holds, the incoming byte is lost and a sticky overrun flag records the event.

A mode input merges the four packet channels into two larger channels or into one. A byte-order input selects which end of the word receives the first byte.

Top module: `rx_pingpong_bank`

## Requirements
- R1: After reset every ready flag and every overrun flag is 0, and every channel starts filling half 0.
- R2: With `msb_first_i`=1 the first byte of a word lands in bits 31:24 and the fourth in bits 7:0. With `msb_first_i`=0 the first byte lands in bits 7:0 and the fourth in bits 31:24.
- R3: When the last byte of a half is accepted, the ready flag of that half rises at the next clock edge, and later bytes go to the other half. The ready flag of channel c, half h is `ready_o[2*c+h]`.
- R4: With `mode_i`=00 each packet channel 0..3 has halves of one word. The voice channel (number 4) always has halves of two words.
- R5: With `mode_i`=01, packet channels 0+1 form one channel addressed as 0, and channels 2+3 form one addressed as 2, each with two-word halves. With `mode_i`=10 or 11, all four form one channel addressed as 0, with four-word halves.
- R6: In a merged mode, writes and reads that name an absorbed channel (1 and 3 in mode 01; 1, 2 and 3 in mode 10/11) change no flag and no stored data.
- R7: A read request (`rd_chan_i`, `rd_half_i`, `rd_word_i`, where `rd_word_i` is the word index inside the half) returns the word on `rd_data_o` one clock after the request is sampled.
- R8: Reading the last word of a half clears its ready flag at that clock edge. Reading any other word leaves the flag as it is.
- R9: A byte that arrives while the half being filled is still ready is dropped. It sets `overrun_o[c]`, which stays 1 until reset, and the stored words and ready flags stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Packet channel grouping: 00 four, 01 two, 10/11 one |
| msb_first_i | input | 1 | 1: first byte goes to the top byte of the word |
| wr_valid_i | input | 1 | Byte write strobe |
| wr_chan_i | input | 3 | Channel tag of the byte (4 = voice) |
| wr_byte_i | input | 8 | Received byte |
| rd_valid_i | input | 1 | Word read strobe |
| rd_chan_i | input | 3 | Channel to read |
| rd_half_i | input | 1 | Half to read |
| rd_word_i | input | 2 | Word index inside the half |
| rd_data_o | output | 32 | Read word, one clock after the request |
| ready_o | output | 10 | Per-half ready flags, bit 2*c+h |
| overrun_o | output | 5 | Sticky per-channel overrun flags |

## Verification
Each byte write is driven on a falling edge and sampled on the next rising edge. The resulting ready and overrun flags are compared on the following falling edge, one clock after the write. A read is driven the same way. Its data word and the cleared ready flag are both compared one full clock after the request, which matches the single output register on the read path. A bench model built from the requirements tracks the fill pointers, flags and stored words, so every comparison uses a value due at that exact cycle. Random traffic in all three grouping modes, including writes and reads to absorbed channels, is mixed with directed sequences for byte order, overrun, voice release and the half-size boundaries.

// File: rtl/rx_pp_pkg.sv
package rx_pp_pkg;

  typedef enum logic [1:0] {
    GRP_FOUR = 2'b00,
    GRP_TWO  = 2'b01,
    GRP_ONE  = 2'b10
  } grp_mode_e;

  // log2 of the number of packet channels merged into one group
  function automatic logic [1:0] half_log2(input logic [1:0] mode, input int max_lg);
    if (int'(mode) > max_lg) return 2'(max_lg);
    return mode;
  endfunction

  function automatic logic [2:0] grp_mask(input logic [1:0] mode, input int max_lg);
    return 3'((1 << half_log2(mode, max_lg)) - 1);
  endfunction

endpackage

// File: rtl/rx_pp_chan_ctrl.sv
module rx_pp_chan_ctrl #(
  parameter int WIDX_W = 2,
  parameter int LANE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rel_i,
  input  logic              rel_half_i,
  input  logic [WIDX_W-1:0] last_word_i,
  output logic              fill_o,
  output logic [WIDX_W-1:0] word_o,
  output logic [LANE_W-1:0] byte_o,
  output logic              accept_o,
  output logic [1:0]        ready_o,
  output logic              ovr_o
);

  logic       word_done;
  logic       half_done;
  logic [1:0] set_m;
  logic [1:0] clr_m;

  assign accept_o  = wr_i & ~ready_o[fill_o];
  assign word_done = accept_o & (&byte_o);
  assign half_done = word_done & (word_o == last_word_i);

  always_comb begin
    set_m = '0;
    clr_m = '0;
    if (half_done) set_m[fill_o] = 1'b1;
    if (rel_i)     clr_m[rel_half_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_o  <= 1'b0;
      word_o  <= '0;
      byte_o  <= '0;
      ready_o <= '0;
      ovr_o   <= 1'b0;
    end else begin
      // a half filling in this cycle wins over a release of the same bit
      ready_o <= (ready_o & ~clr_m) | set_m;
      if (accept_o) byte_o <= byte_o + 1'b1;
      if (half_done) begin
        word_o <= '0;
        fill_o <= ~fill_o;
      end else if (word_done) begin
        word_o <= word_o + 1'b1;
      end
      if (wr_i && ready_o[fill_o]) ovr_o <= 1'b1;
    end
  end

endmodule

// File: rtl/rx_pp_word_store.sv
module rx_pp_word_store #(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 32,
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LANE_W = $clog2(WORD_W / 8)
) (
  input  logic              clk_i,
  input  logic              wr_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [LANE_W-1:0] wr_lane_i,
  input  logic [7:0]        wr_byte_i,
  input  logic              rd_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o
);

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_i) mem[wr_addr_i][wr_lane_i*8 +: 8] <= wr_byte_i;
    if (rd_i) rd_data_o <= mem[rd_addr_i];
  end

endmodule

// File: rtl/rx_pingpong_bank.sv
module rx_pingpong_bank
  import rx_pp_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int PKT_FIFOS  = 4,
  parameter int PKT_HALF   = 1,
  parameter int VOICE_HALF = 2,
  localparam int NUM_CH    = PKT_FIFOS + 1,
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int MAX_LG    = $clog2(PKT_FIFOS),
  localparam int MAX_HALF  = (PKT_HALF * PKT_FIFOS > VOICE_HALF) ? PKT_HALF * PKT_FIFOS : VOICE_HALF,
  localparam int WIDX_W    = (MAX_HALF > 1) ? $clog2(MAX_HALF) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          mode_i,
  input  logic                msb_first_i,
  input  logic                wr_valid_i,
  input  logic [CH_W-1:0]     wr_chan_i,
  input  logic [7:0]          wr_byte_i,
  input  logic                rd_valid_i,
  input  logic [CH_W-1:0]     rd_chan_i,
  input  logic                rd_half_i,
  input  logic [WIDX_W-1:0]   rd_word_i,
  output logic [WORD_W-1:0]   rd_data_o,
  output logic [2*NUM_CH-1:0] ready_o,
  output logic [NUM_CH-1:0]   overrun_o
);

  localparam int VOICE_CH = PKT_FIFOS;
  localparam int LANE_W   = $clog2(WORD_W / 8);
  localparam int P_DEPTH  = 2 * PKT_HALF * PKT_FIFOS;
  localparam int V_DEPTH  = 2 * VOICE_HALF;
  localparam int PAW      = (P_DEPTH > 1) ? $clog2(P_DEPTH) : 1;
  localparam int VAW      = (V_DEPTH > 1) ? $clog2(V_DEPTH) : 1;

  logic [1:0]        lg;
  logic [2:0]        mask;
  int                pkt_half_w;
  logic [WIDX_W-1:0] pkt_last;
  logic              wr_live;
  logic              rd_live;

  function automatic logic chan_live(input logic [CH_W-1:0] ch, input logic [2:0] m);
    if (int'(ch) == VOICE_CH) return 1'b1;
    if (int'(ch) > VOICE_CH) return 1'b0;
    return (3'(ch) & m) == 3'b000;
  endfunction

  assign lg         = half_log2(mode_i, MAX_LG);
  assign mask       = grp_mask(mode_i, MAX_LG);
  assign pkt_half_w = PKT_HALF << lg;
  assign pkt_last   = WIDX_W'(pkt_half_w - 1);
  assign wr_live    = chan_live(wr_chan_i, mask);
  assign rd_live    = chan_live(rd_chan_i, mask);

  logic [NUM_CH-1:0] wr_hit;
  logic [NUM_CH-1:0] rel_hit;
  logic [NUM_CH-1:0] acc_a;
  logic [NUM_CH-1:0] fill_a;
  logic [WIDX_W-1:0] word_a [NUM_CH];
  logic [LANE_W-1:0] byte_a [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [WIDX_W-1:0] last_w;
    logic [1:0]        rdy;

    assign last_w     = (c == VOICE_CH) ? WIDX_W'(VOICE_HALF - 1) : pkt_last;
    assign wr_hit[c]  = wr_valid_i && wr_live && (int'(wr_chan_i) == c);
    assign rel_hit[c] = rd_valid_i && rd_live && (int'(rd_chan_i) == c) &&
                        ((rd_word_i & last_w) == last_w);

    rx_pp_chan_ctrl #(
      .WIDX_W (WIDX_W),
      .LANE_W (LANE_W)
    ) u_ctrl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        (wr_hit[c]),
      .rel_i       (rel_hit[c]),
      .rel_half_i  (rd_half_i),
      .last_word_i (last_w),
      .fill_o      (fill_a[c]),
      .word_o      (word_a[c]),
      .byte_o      (byte_a[c]),
      .accept_o    (acc_a[c]),
      .ready_o     (rdy),
      .ovr_o       (overrun_o[c])
    );

    assign ready_o[2*c +: 2] = rdy;
  end

  // write-side select of the addressed channel's fill state
  logic              sel_acc;
  logic              sel_fill;
  logic [WIDX_W-1:0] sel_word;
  logic [LANE_W-1:0] sel_byte;

  always_comb begin
    sel_acc  = 1'b0;
    sel_fill = 1'b0;
    sel_word = '0;
    sel_byte = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (int'(wr_chan_i) == c) begin
        sel_acc  = acc_a[c];
        sel_fill = fill_a[c];
        sel_word = word_a[c];
        sel_byte = byte_a[c];
      end
    end
  end

  logic              wr_is_voice;
  logic              rd_is_voice;
  logic [LANE_W-1:0] wr_lane;
  logic [PAW-1:0]    p_wr_addr;
  logic [PAW-1:0]    p_rd_addr;
  logic [VAW-1:0]    v_wr_addr;
  logic [VAW-1:0]    v_rd_addr;

  assign wr_is_voice = int'(wr_chan_i) == VOICE_CH;
  assign rd_is_voice = int'(rd_chan_i) == VOICE_CH;
  assign wr_lane     = msb_first_i ? ~sel_byte : sel_byte;

  // channel c of group base b lives at words [2*PKT_HALF*b, ...), half h after h*half_len words
  assign p_wr_addr = PAW'(int'(wr_chan_i) * 2 * PKT_HALF + int'(sel_fill) * pkt_half_w + int'(sel_word));
  assign p_rd_addr = PAW'(int'(rd_chan_i) * 2 * PKT_HALF + int'(rd_half_i) * pkt_half_w +
                          int'(rd_word_i & pkt_last));
  assign v_wr_addr = VAW'(int'(sel_fill) * VOICE_HALF + int'(sel_word));
  assign v_rd_addr = VAW'(int'(rd_half_i) * VOICE_HALF + int'(rd_word_i & WIDX_W'(VOICE_HALF - 1)));

  logic [WORD_W-1:0] p_rdata;
  logic [WORD_W-1:0] v_rdata;
  logic              rd_voice_q;

  rx_pp_word_store #(
    .DEPTH  (P_DEPTH),
    .WORD_W (WORD_W)
  ) u_pkt_store (
    .clk_i     (clk_i),
    .wr_i      (sel_acc && !wr_is_voice),
    .wr_addr_i (p_wr_addr),
    .wr_lane_i (wr_lane),
    .wr_byte_i (wr_byte_i),
    .rd_i      (rd_valid_i && !rd_is_voice),
    .rd_addr_i (p_rd_addr),
    .rd_data_o (p_rdata)
  );

  rx_pp_word_store #(
    .DEPTH  (V_DEPTH),
    .WORD_W (WORD_W)
  ) u_voice_store (
    .clk_i     (clk_i),
    .wr_i      (sel_acc && wr_is_voice),
    .wr_addr_i (v_wr_addr),
    .wr_lane_i (wr_lane),
    .wr_byte_i (wr_byte_i),
    .rd_i      (rd_valid_i && rd_is_voice),
    .rd_addr_i (v_rd_addr),
    .rd_data_o (v_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rd_voice_q <= 1'b0;
    else if (rd_valid_i) rd_voice_q <= rd_is_voice;
  end

  assign rd_data_o = rd_voice_q ? v_rdata : p_rdata;

endmodule

// File: rtl/rx_pingpong_bank_chk.sv
module rx_pingpong_bank_chk
  import rx_pp_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int CH_W   = 3,
  parameter int MAX_LG = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [1:0]          mode_i,
  input logic                wr_valid_i,
  input logic [CH_W-1:0]     wr_chan_i,
  input logic                rd_valid_i,
  input logic [CH_W-1:0]     rd_chan_i,
  input logic                rd_half_i,
  input logic [2*NUM_CH-1:0] ready_o,
  input logic [NUM_CH-1:0]   overrun_o
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    // R9
    ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(overrun_o[c]) |-> overrun_o[c]);

    // R9
    ovr_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(overrun_o[c]) |-> $past(wr_valid_i && int'(wr_chan_i) == c && ready_o[2*c +: 2] != 2'b00));

    for (genvar h = 0; h < 2; h++) begin : g_h
      // R3
      rdy_set_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ready_o[2*c+h]) |-> $past(wr_valid_i && int'(wr_chan_i) == c));

      // R8
      rdy_clr_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(ready_o[2*c+h]) |-> $past(rd_valid_i && int'(rd_chan_i) == c && int'(rd_half_i) == h));
    end

    if (c < NUM_CH - 1) begin : g_pkt
      // R6
      absorbed_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(|ready_o[2*c +: 2]) |-> $past((3'(c) & grp_mask(mode_i, MAX_LG)) == 3'b000));
    end
  end

endmodule

bind rx_pingpong_bank rx_pingpong_bank_chk #(
  .NUM_CH (NUM_CH),
  .CH_W   (CH_W),
  .MAX_LG (MAX_LG)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .wr_valid_i (wr_valid_i),
  .wr_chan_i  (wr_chan_i),
  .rd_valid_i (rd_valid_i),
  .rd_chan_i  (rd_chan_i),
  .rd_half_i  (rd_half_i),
  .ready_o    (ready_o),
  .overrun_o  (overrun_o)
);

// File: tb/tb_rx_pingpong_bank.sv
module tb_rx_pingpong_bank;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic        msb_first_i = 1'b1;
  logic        wr_valid_i = 1'b0;
  logic [2:0]  wr_chan_i = '0;
  logic [7:0]  wr_byte_i = '0;
  logic        rd_valid_i = 1'b0;
  logic [2:0]  rd_chan_i = '0;
  logic        rd_half_i = 1'b0;
  logic [1:0]  rd_word_i = '0;
  logic [31:0] rd_data_o;
  logic [9:0]  ready_o;
  logic [4:0]  overrun_o;

  always #10 clk_i = ~clk_i;

  rx_pingpong_bank dut (
    .clk_i, .rst_ni, .mode_i, .msb_first_i, .wr_valid_i, .wr_chan_i, .wr_byte_i,
    .rd_valid_i, .rd_chan_i, .rd_half_i, .rd_word_i, .rd_data_o, .ready_o, .overrun_o
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model
  logic [31:0] m_pkt [8];
  logic [31:0] m_voc [4];
  int          m_fill [5];
  int          m_word [5];
  int          m_byte [5];
  logic [1:0]  m_rdy  [5];
  logic        m_ovr  [5];

  function automatic int lg_of(input logic [1:0] m);
    return (m >= 2) ? 2 : int'(m);
  endfunction

  function automatic int half_len(input int c);
    return (c == 4) ? 2 : (1 << lg_of(mode_i));
  endfunction

  function automatic bit live(input int c);
    if (c == 4) return 1;
    if (c > 4) return 0;
    return (c % (1 << lg_of(mode_i))) == 0;
  endfunction

  function automatic logic [9:0] exp_rdy();
    logic [9:0] v;
    for (int c = 0; c < 5; c++) v[2*c +: 2] = m_rdy[c];
    return v;
  endfunction

  function automatic logic [4:0] exp_ovr();
    logic [4:0] v;
    for (int c = 0; c < 5; c++) v[c] = m_ovr[c];
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_flags(input string req);
    check(ready_o === exp_rdy(), {req, " ready"}, 32'(ready_o), 32'(exp_rdy()));
    check(overrun_o === exp_ovr(), {req, " overrun"}, 32'(overrun_o), 32'(exp_ovr()));
  endtask

  task automatic model_reset();
    for (int c = 0; c < 5; c++) begin
      m_fill[c] = 0; m_word[c] = 0; m_byte[c] = 0; m_rdy[c] = 2'b00; m_ovr[c] = 1'b0;
    end
  endtask

  task automatic model_write(input int c, input logic [7:0] b);
    int lane;
    int addr;
    if (!live(c)) return;                 // R6
    if (m_rdy[c][m_fill[c]]) begin        // R9
      m_ovr[c] = 1'b1;
      return;
    end
    lane = msb_first_i ? 3 - m_byte[c] : m_byte[c];  // R2
    if (c == 4) begin
      addr = m_fill[c] * 2 + m_word[c];
      m_voc[addr][lane*8 +: 8] = b;
    end else begin
      addr = c * 2 + m_fill[c] * half_len(c) + m_word[c];  // R5 concatenation
      m_pkt[addr][lane*8 +: 8] = b;
    end
    m_byte[c]++;
    if (m_byte[c] == 4) begin
      m_byte[c] = 0;
      m_word[c]++;
      if (m_word[c] == half_len(c)) begin // R3 / R4
        m_word[c] = 0;
        m_rdy[c][m_fill[c]] = 1'b1;
        m_fill[c] = 1 - m_fill[c];
      end
    end
  endtask

  task automatic do_reset(input logic [1:0] mode, input logic msb);
    @(negedge clk_i);
    rst_ni = 1'b0;
    mode_i = mode;
    msb_first_i = msb;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    model_reset();
    @(negedge clk_i);
    // R1
    check(ready_o === 10'b0, "R1 ready", 32'(ready_o), 32'd0);
    check(overrun_o === 5'b0, "R1 overrun", 32'(overrun_o), 32'd0);
  endtask

  task automatic wr(input int c, input logic [7:0] b);
    @(negedge clk_i);
    wr_valid_i = 1'b1; wr_chan_i = 3'(c); wr_byte_i = b;
    @(negedge clk_i);
    wr_valid_i = 1'b0;
    model_write(c, b);
    check_flags("R3/R9");
  endtask

  task automatic rd(input int c, input int h, input int w, output logic [31:0] got);
    logic [31:0] exp;
    bit          cmp;
    @(negedge clk_i);
    rd_valid_i = 1'b1; rd_chan_i = 3'(c); rd_half_i = h[0]; rd_word_i = 2'(w);
    @(negedge clk_i);
    rd_valid_i = 1'b0;
    got = rd_data_o;
    cmp = live(c) && m_rdy[c][h];
    if (cmp) begin
      exp = (c == 4) ? m_voc[h*2 + w] : m_pkt[c*2 + h*half_len(c) + w];
      check(got === exp, "R7 data", got, exp);                // R7
    end
    if (live(c) && w == half_len(c) - 1) m_rdy[c][h] = 1'b0;  // R8
    check_flags("R8");
  endtask

  task automatic rd_half(input int c, input int h);
    logic [31:0] d;
    for (int w = 0; w < half_len(c); w++) rd(c, h, w, d);
  endtask

  task automatic random_phase(input logic [1:0] mode, input logic msb, input int ops);
    logic [31:0] d;
    do_reset(mode, msb);
    for (int i = 0; i < ops; i++) begin
      int c;
      c = int'($urandom_range(0, 4));
      if ($urandom_range(0, 9) < 6) begin
        wr(c, 8'($urandom));
      end else begin
        int h;
        h = int'($urandom_range(0, 1));
        if (live(c) && $urandom_range(0, 3) != 0 && m_rdy[c] != 2'b00)
          rd_half(c, m_rdy[c][0] ? 0 : 1);
        else
          rd(c, h, int'($urandom_range(0, half_len(c) - 1)), d);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed_2024));

    // R4 R2: one-word halves, first byte in the top lane
    do_reset(2'b00, 1'b1);
    wr(0, 8'hAA); wr(0, 8'hBB); wr(0, 8'hCC);
    check(ready_o[0] === 1'b0, "R3 not yet full", 32'(ready_o), 32'd0);
    wr(0, 8'hDD);
    check(ready_o[1:0] === 2'b01, "R3 half0 ready", 32'(ready_o), 32'd1);
    rd(0, 0, 0, d);
    check(d === 32'hAABBCCDD, "R2 msb first", d, 32'hAABBCCDD);
    check(ready_o[0] === 1'b0, "R8 released", 32'(ready_o), 32'd0);

    // R2: first byte in the bottom lane, second half used
    msb_first_i = 1'b0;
    wr(0, 8'h11); wr(0, 8'h22); wr(0, 8'h33); wr(0, 8'h44);
    check(ready_o[1:0] === 2'b10, "R3 half1 ready", 32'(ready_o), 32'd2);
    rd(0, 1, 0, d);
    check(d === 32'h44332211, "R2 lsb first", d, 32'h44332211);

    // R9: both halves of channel 1 held, extra byte dropped
    msb_first_i = 1'b1;
    for (int i = 0; i < 8; i++) wr(1, 8'(8'h50 + i));
    check(ready_o[3:2] === 2'b11, "R9 both held", 32'(ready_o[3:2]), 32'd3);
    wr(1, 8'hEE);
    check(overrun_o[1] === 1'b1, "R9 overrun set", 32'(overrun_o), 32'd2);
    rd(1, 0, 0, d);
    check(d === 32'h50515253, "R9 data intact", d, 32'h50515253);
    wr(1, 8'h77);
    check(overrun_o[1] === 1'b1, "R9 sticky", 32'(overrun_o), 32'd2);

    // R4 R8: voice halves of two words, release on second word only
    for (int i = 0; i < 8; i++) wr(4, 8'(8'h80 + i));
    check(ready_o[8] === 1'b1, "R4 voice ready", 32'(ready_o), 32'h100);
    rd(4, 0, 0, d);
    check(ready_o[8] === 1'b1, "R8 first word keeps", 32'(ready_o), 32'h100);
    rd(4, 0, 1, d);
    check(d === 32'h84858687, "R4 voice word1", d, 32'h84858687);
    check(ready_o[8] === 1'b0, "R8 second word frees", 32'(ready_o), 32'd0);

    // R5 R6: paired grouping
    do_reset(2'b01, 1'b1);
    for (int i = 0; i < 4; i++) wr(1, 8'(i));
    check(ready_o === 10'b0 && overrun_o === 5'b0, "R6 absorbed write", 32'(ready_o), 32'd0);
    for (int i = 0; i < 4; i++) wr(0, 8'(8'hC0 + i));
    check(ready_o[0] === 1'b0, "R5 half not full at 4", 32'(ready_o), 32'd0);
    for (int i = 4; i < 8; i++) wr(0, 8'(8'hC0 + i));
    check(ready_o[0] === 1'b1, "R5 half full at 8", 32'(ready_o), 32'd1);
    rd(1, 0, 1, d);
    check(ready_o[0] === 1'b1, "R6 absorbed read", 32'(ready_o), 32'd1);
    rd(0, 0, 1, d);
    check(d === 32'hC4C5C6C7, "R5 second word", d, 32'hC4C5C6C7);

    // R5: single group, four-word halves
    do_reset(2'b10, 1'b0);
    for (int i = 0; i < 15; i++) wr(0, 8'(i));
    check(ready_o[0] === 1'b0, "R5 one group at 15", 32'(ready_o), 32'd0);
    wr(0, 8'd15);
    check(ready_o[0] === 1'b1, "R5 one group at 16", 32'(ready_o), 32'd1);
    wr(2, 8'h99);
    check(ready_o[5:2] === 4'b0, "R6 channel 2 absorbed", 32'(ready_o), 32'd1);
    rd(0, 0, 3, d);
    check(d === 32'h0F0E0D0C, "R5 last word", d, 32'h0F0E0D0C);

    // mode 11 behaves as single group
    do_reset(2'b11, 1'b1);
    for (int i = 0; i < 16; i++) wr(0, 8'(i));
    check(ready_o[0] === 1'b1, "R5 mode 11", 32'(ready_o), 32'd1);

    random_phase(2'b00, 1'b1, 1500);
    random_phase(2'b01, 1'b0, 1500);
    random_phase(2'b10, 1'b1, 1500);
    random_phase(2'b00, 1'b0, 1000);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule